// File: doc/BRIEF.md
# Manchester II Frame Decoder

The block takes a Manchester II encoded line and turns it back into framed serial words. The line arrives either as a bipolar pair, with one wire for the high state and one for the low state, or as a single unipolar level. A select input picks which form is used. Everything runs on one decoder clock at twelve times the bit rate. The block measures the number of clocks between line transitions. When it sees a sync transition it reports whether the sync was a command sync or a data sync. It then times each data bit from the mid-sync transition and presents the bits one by one on a serial output with a one-cycle shift strobe.

The number of data bits in a word comes from a 5-bit length code. After the data bits the block checks one parity bit, with even or odd sense set by its own select. A word that arrives whole, with every mid-bit transition present and no transition at a forbidden phase, raises a word-valid pulse one bit period long at the end of the frame. A synchronous decoder reset drops any frame in progress and sends the block back to searching for a sync.

Top module: `mdec_top`

## Requirements
- R1: With `sel_uni`=1 the line level is `uni_in` and the pair `bip_one`/`bip_zero` has no effect. With `sel_uni`=0 the level comes from the pair and `uni_in` has no effect.
- R2: In bipolar mode, `bip_one`=1 with `bip_zero`=0 means a high level and `bip_one`=0 with `bip_zero`=1 means a low level. When both are equal the previous level is held.
- R3: While searching, a transition that ends a run of 15 to 21 clocks at one level is a sync. If the level before it was high, `cmd_sync` goes to 1 and `data_sync` to 0. If it was low, the two flags take the opposite values. The two flags are never high together, and they hold until the next sync or a reset.
- R4: A run of 22 clocks or more, or of 14 clocks or fewer, is not taken as a sync. In that case no word starts and the flags keep their values.
- R5: The word length is latched when a sync is detected. It is code+2 data bits for codes 0 to 26 and 28 data bits for codes 27 to 31.
- R6: The first data bit begins 18 clocks after the mid-sync transition is registered. Each bit lasts 12 clocks. A bit's value is the level 3 clocks into the bit, with high meaning 1. Bits come out first-received first on `ser_data`, with a one-cycle `shift_stb` 4 clocks after each bit start. The parity bit is not shifted out.
- R7: `take_data` rises at the start of the first data bit and stays high for exactly 12×(word length) clocks.
- R8: The word is dropped and no `word_ok` follows if a bit has no transition at clock 4 to 8 of the bit, or if a transition falls at clock 3 or clock 9 of a bit.
- R9: With `odd_par`=1 the count of ones over the data bits and the parity bit must be odd; with `odd_par`=0 it must be even. A mismatch suppresses `word_ok`.
- R10: `word_ok` rises 12 clocks after the parity bit begins and stays high for 12 clocks.
- R11: `dec_rst`=1 on a clock edge makes `take_data`, `word_ok`, `cmd_sync` and `data_sync` all 0 in the next cycle. The frame in progress is dropped.
- R12: `rst_n`=0 forces every output to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | decoder clock, 12 × bit rate |
| rst_n | input | 1 | asynchronous master reset, active low |
| dec_rst | input | 1 | synchronous decoder reset, active high |
| sel_uni | input | 1 | 1 = unipolar line, 0 = bipolar pair |
| uni_in | input | 1 | unipolar line level |
| bip_one | input | 1 | bipolar high-state wire |
| bip_zero | input | 1 | bipolar low-state wire |
| len_code | input | 5 | word length code |
| odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| cmd_sync | output | 1 | last sync was a command sync |
| data_sync | output | 1 | last sync was a data sync |
| take_data | output | 1 | high over the data-bit interval |
| ser_data | output | 1 | decoded serial bit |
| shift_stb | output | 1 | one-cycle strobe per new data bit |
| word_ok | output | 1 | one-bit-period pulse for a good word |

## Verification
Every result is timed from the clock edge that registers the mid-sync level, called p0. The sync flags are valid from p0+1 and `take_data` rises at p0+18. The strobe for bit k comes at p0+22+12k, and `word_ok` rises at p0+18+12×(length+1). The bench records p0 when it drives the second half of the sync. A monitor samples on the falling edge and stores the exact cycle of each rise and the width of each pulse, and these are compared with the figures above. The decoder-reset effect is checked on the falling edge that directly follows the single reset edge. The master reset is checked shortly after it is applied, with no clock edge in between.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SYNC2 = 2'd1,
        ST_DATA  = 2'd2
    } mdec_state_e;
endpackage

// File: rtl/mdec_line.sv
module mdec_line (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_uni_i,
    input  logic uni_i,
    input  logic one_i,
    input  logic zero_i,
    output logic lvl_o,
    output logic prv_o,
    output logic edge_o
);
    typedef struct packed {
        logic lvl;
        logic prv;
    } line_t;

    line_t q, d;

    always_comb begin
        d = q;
        if (sel_uni_i) begin
            d.lvl = uni_i;
        end else if (one_i && !zero_i) begin
            d.lvl = 1'b1;
        end else if (!one_i && zero_i) begin
            d.lvl = 1'b0;
        end
        d.prv = q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o  = q.lvl;
    assign prv_o  = q.prv;
    assign edge_o = q.lvl ^ q.prv;

    // R2: an undecided bipolar pair keeps the registered level
    p_bip_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_uni_i && (one_i == zero_i)) |=> (lvl_o == $past(lvl_o)));
endmodule

// File: rtl/mdec_span.sv
module mdec_span #(
    parameter int SPAN_LO = 15,
    parameter int SPAN_HI = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(SPAN_HI + 1) + 1;
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(SPAN_LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(SPAN_HI);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } span_t;

    span_t q, d;

    always_comb begin
        d = q;
        if (edge_i)             d.cnt = CNT_W'(1);
        else if (q.cnt != '1)   d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.cnt <= '1;
        else        q <= d;
    end

    assign hit_o = edge_i && (q.cnt >= LO_C) && (q.cnt <= HI_C);

    // R4: a span is counted from the previous transition, so after one it restarts
    p_span_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> !hit_o);
endmodule

// File: rtl/mdec_frame.sv
module mdec_frame
    import mdec_pkg::*;
#(
    parameter int OVS      = 12,
    parameter int DATA_TOL = 2,
    parameter int MIN_BITS = 2,
    parameter int MAX_BITS = 28,
    parameter int LEN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_rst_i,
    input  logic             sync_hit_i,
    input  logic             edge_i,
    input  logic             lvl_i,
    input  logic             prv_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             odd_i,
    output logic             cmd_o,
    output logic             dat_o,
    output logic             take_o,
    output logic             sdo_o,
    output logic             stb_o,
    output logic             ok_o
);
    localparam int HALF      = OVS / 2;
    localparam int SYNC_HALF = 3 * HALF;
    localparam int TK_W      = $clog2(SYNC_HALF);
    localparam int BI_W      = $clog2(MAX_BITS + 1);
    localparam int VLD_W     = $clog2(OVS + 1);

    localparam logic [TK_W-1:0]  TK_SYNC_END = TK_W'(SYNC_HALF - 1);
    localparam logic [TK_W-1:0]  TK_SYNC_ERL = TK_W'(SYNC_HALF - DATA_TOL);
    localparam logic [TK_W-1:0]  TK_BIT_END  = TK_W'(OVS - 1);
    localparam logic [TK_W-1:0]  TK_SAMPLE   = TK_W'(OVS / 4);
    localparam logic [TK_W-1:0]  TK_MID_LO   = TK_W'(HALF - DATA_TOL);
    localparam logic [TK_W-1:0]  TK_MID_HI   = TK_W'(HALF + DATA_TOL);
    localparam logic [TK_W-1:0]  TK_BND_LO   = TK_W'(DATA_TOL);
    localparam logic [TK_W-1:0]  TK_BND_HI   = TK_W'(OVS - DATA_TOL);
    localparam logic [VLD_W-1:0] VLD_LEN     = VLD_W'(OVS);

    typedef struct packed {
        mdec_state_e      st;
        logic [TK_W-1:0]  tk;
        logic [BI_W-1:0]  bi;
        logic [BI_W-1:0]  nb;
        logic             seen;
        logic             par;
        logic             cmd;
        logic             dat;
        logic             sdo;
        logic             stb;
        logic [VLD_W-1:0] vld;
    } frame_t;

    frame_t q, d;

    function automatic logic [BI_W-1:0] len_of(input logic [LEN_W-1:0] c);
        if (int'(c) > MAX_BITS - MIN_BITS) return BI_W'(MAX_BITS);
        else                               return BI_W'(int'(c) + MIN_BITS);
    endfunction

    logic in_mid, in_bnd, bad_edge;
    assign in_mid   = (q.tk >= TK_MID_LO) && (q.tk <= TK_MID_HI);
    assign in_bnd   = (q.tk <= TK_BND_LO) || (q.tk >= TK_BND_HI);
    assign bad_edge = edge_i && !in_mid && !in_bnd;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (q.vld != '0) d.vld = q.vld - 1'b1;
        unique case (q.st)
            ST_HUNT: begin
                if (sync_hit_i) begin
                    d.st   = ST_SYNC2;
                    d.tk   = TK_W'(1);
                    d.cmd  = prv_i;
                    d.dat  = !prv_i;
                    d.nb   = len_of(len_code_i);
                    d.bi   = '0;
                    d.par  = 1'b0;
                    d.seen = 1'b0;
                end
            end
            ST_SYNC2: begin
                if (edge_i && (q.tk < TK_SYNC_ERL)) begin
                    d.st = ST_HUNT;
                end else if (q.tk == TK_SYNC_END) begin
                    d.st = ST_DATA;
                    d.tk = '0;
                end else begin
                    d.tk = q.tk + 1'b1;
                end
            end
            ST_DATA: begin
                d.tk = (q.tk == TK_BIT_END) ? '0 : q.tk + 1'b1;
                if (q.tk == TK_SAMPLE) begin
                    d.par = q.par ^ lvl_i;
                    if (q.bi < q.nb) begin
                        d.sdo = lvl_i;
                        d.stb = 1'b1;
                    end
                end
                if (edge_i && in_mid) d.seen = 1'b1;
                if (bad_edge) begin
                    d.st = ST_HUNT;
                end else if (q.tk == TK_BIT_END) begin
                    if (!q.seen) begin
                        d.st = ST_HUNT;
                    end else if (q.bi == q.nb) begin
                        d.st = ST_HUNT;
                        if (q.par == odd_i) d.vld = VLD_LEN;
                    end else begin
                        d.bi   = q.bi + 1'b1;
                        d.seen = 1'b0;
                    end
                end
            end
            default: d.st = ST_HUNT;
        endcase
        if (dec_rst_i) begin
            d.st  = ST_HUNT;
            d.cmd = 1'b0;
            d.dat = 1'b0;
            d.vld = '0;
            d.stb = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign cmd_o  = q.cmd;
    assign dat_o  = q.dat;
    assign take_o = (q.st == ST_DATA) && (q.bi < q.nb);
    assign sdo_o  = q.sdo;
    assign stb_o  = q.stb;
    assign ok_o   = (q.vld != '0);

    // R3: sync type flags are exclusive
    p_flags_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_o, dat_o}));
    // R7: the data window only opens after a sync was classified
    p_take_after_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cmd_o || dat_o));
    // R6: a shift strobe lies inside the data window
    p_strobe_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> take_o);
    // R10: the word pulse starts only as a frame in progress finishes
    p_ok_ends_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> ($past(q.st == ST_DATA) && !take_o));
    // R11: decoder reset clears the outputs on the next cycle
    p_decrst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rst_i |=> (!take_o && !ok_o && !cmd_o && !dat_o));
endmodule

// File: rtl/mdec_top.sv
module mdec_top #(
    parameter int OVS      = 12,
    parameter int SYNC_TOL = 3,
    parameter int DATA_TOL = 2,
    parameter int MIN_BITS = 2,
    parameter int MAX_BITS = 28,
    parameter int LEN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_rst,
    input  logic             sel_uni,
    input  logic             uni_in,
    input  logic             bip_one,
    input  logic             bip_zero,
    input  logic [LEN_W-1:0] len_code,
    input  logic             odd_par,
    output logic             cmd_sync,
    output logic             data_sync,
    output logic             take_data,
    output logic             ser_data,
    output logic             shift_stb,
    output logic             word_ok
);
    localparam int SYNC_HALF = 3 * (OVS / 2);

    logic lvl, prv, edge_seen, sync_hit;

    mdec_line i_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_uni_i (sel_uni),
        .uni_i     (uni_in),
        .one_i     (bip_one),
        .zero_i    (bip_zero),
        .lvl_o     (lvl),
        .prv_o     (prv),
        .edge_o    (edge_seen)
    );

    mdec_span #(
        .SPAN_LO (SYNC_HALF - SYNC_TOL),
        .SPAN_HI (SYNC_HALF + SYNC_TOL)
    ) i_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_seen),
        .hit_o  (sync_hit)
    );

    mdec_frame #(
        .OVS      (OVS),
        .DATA_TOL (DATA_TOL),
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_rst_i  (dec_rst),
        .sync_hit_i (sync_hit),
        .edge_i     (edge_seen),
        .lvl_i      (lvl),
        .prv_i      (prv),
        .len_code_i (len_code),
        .odd_i      (odd_par),
        .cmd_o      (cmd_sync),
        .dat_o      (data_sync),
        .take_o     (take_data),
        .sdo_o      (ser_data),
        .stb_o      (shift_stb),
        .ok_o       (word_ok)
    );
endmodule

// File: tb/test_mdec_top.sv
module test_mdec_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_rst = 1'b0;
    logic sel_uni = 1'b1;
    logic uni_in = 1'b0;
    logic bip_one = 1'b0;
    logic bip_zero = 1'b1;
    logic [4:0] len_code = 5'd0;
    logic odd_par = 1'b0;
    logic cmd_sync, data_sync, take_data, ser_data, shift_stb, word_ok;

    always #5 clk = ~clk;

    mdec_top i_mdec_top (
        .clk(clk), .rst_n(rst_n), .dec_rst(dec_rst), .sel_uni(sel_uni),
        .uni_in(uni_in), .bip_one(bip_one), .bip_zero(bip_zero),
        .len_code(len_code), .odd_par(odd_par), .cmd_sync(cmd_sync),
        .data_sync(data_sync), .take_data(take_data), .ser_data(ser_data),
        .shift_stb(shift_stb), .word_ok(word_ok)
    );

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor, sampled away from the active edge
    logic [27:0] cap;
    int     ncap, take_cnt, ok_cnt;
    longint take_rise, ok_rise, stb_first;
    logic   take_prev, ok_prev;
    always @(negedge clk) begin
        if (shift_stb) begin
            if (ncap == 0) stb_first = cyc;
            cap  = {cap[26:0], ser_data};
            ncap = ncap + 1;
        end
        if (take_data) begin
            if (!take_prev) take_rise = cyc;
            take_cnt = take_cnt + 1;
        end
        if (word_ok) begin
            if (!ok_prev) ok_rise = cyc;
            ok_cnt = ok_cnt + 1;
        end
        take_prev = take_data;
        ok_prev   = word_ok;
    end

    task automatic mon_clear();
        cap = '0; ncap = 0; take_cnt = 0; ok_cnt = 0;
        take_rise = -1; ok_rise = -1; stb_first = -1;
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    logic bip_mode = 1'b0;

    task automatic set_line(input logic l);
        if (bip_mode) begin bip_one = l; bip_zero = !l; uni_in = !l; end
        else          begin uni_in = l; bip_one = !l; bip_zero = l; end
    endtask

    task automatic drive(input logic l, input int n);
        set_line(l);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_len(input logic [4:0] c);
        return (c > 5'd26) ? 28 : int'(c) + 2;
    endfunction

    longint p0;
    logic   ecmd = 1'b0, edat = 1'b0;

    // fault: 0 none, 1 no mid-bit transition, 2 extra transition at clock 9, 3 bipolar pair idle in second half
    task automatic send_frame(input logic cmd, input logic [4:0] code, input logic [27:0] data,
                              input logic odd, input logic badp, input int fault, input int fbit,
                              input int sh1, input int rstbit);
        int n;
        logic [27:0] dm;
        logic par;
        n  = exp_len(code);
        dm = data & ((28'd1 << n) - 28'd1);
        if (n == 28) dm = data;
        par = (^dm) ^ odd ^ badp;
        sel_uni  = !bip_mode;
        len_code = code;
        odd_par  = odd;
        mon_clear();
        drive(!cmd, 30);
        drive(cmd, sh1);
        p0 = cyc + 1;
        drive(!cmd, 18);
        for (int k = 0; k <= n; k++) begin
            logic b;
            b = (k < n) ? dm[n-1-k] : par;
            if (k == rstbit) begin
                set_line(b);
                dec_rst = 1'b1;
                @(negedge clk);
                dec_rst = 1'b0;
                chk("R11", "take_data after decoder reset", take_data, 0);
                chk("R11", "sync flags after decoder reset", {cmd_sync, data_sync}, 0);
                chk("R11", "word_ok after decoder reset", word_ok, 0);
                repeat (5) @(negedge clk);
                drive(!b, 6);
            end else if (k == fbit && fault == 1) begin
                drive(b, 12);
            end else if (k == fbit && fault == 2) begin
                drive(b, 6); drive(!b, 3); drive(b, 3);
            end else if (k == fbit && fault == 3) begin
                drive(b, 6);
                bip_one = 1'b0; bip_zero = 1'b0;
                repeat (6) @(negedge clk);
            end else begin
                drive(b, 6); drive(!b, 6);
            end
        end
        repeat (20) @(negedge clk);
    endtask

    typedef struct packed {
        logic        cmd;
        logic [4:0]  code;
        logic [27:0] data;
        logic        odd;
        logic        badp;
        logic [1:0]  fault;
        logic [4:0]  fbit;
        logic        bip;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd14, 28'h000A5C3, 1'b1, 1'b0, 2'd0, 5'd0, 1'b0},
        '{1'b0, 5'd0,  28'h0000002, 1'b0, 1'b0, 2'd0, 5'd0, 1'b1},
        '{1'b1, 5'd26, 28'hB3C5A71, 1'b0, 1'b0, 2'd0, 5'd0, 1'b0},
        '{1'b0, 5'd31, 28'h0123456, 1'b1, 1'b0, 2'd0, 5'd0, 1'b1},
        '{1'b1, 5'd6,  28'h00000FF, 1'b1, 1'b1, 2'd0, 5'd0, 1'b0},
        '{1'b0, 5'd6,  28'h000003C, 1'b0, 1'b0, 2'd1, 5'd2, 1'b0},
        '{1'b1, 5'd10, 28'h0000ABC, 1'b0, 1'b0, 2'd2, 5'd5, 1'b0},
        '{1'b0, 5'd6,  28'h0000081, 1'b1, 1'b0, 2'd3, 5'd0, 1'b1},
        '{1'b0, 5'd3,  28'h0000000, 1'b0, 1'b0, 2'd0, 5'd0, 1'b0}
    };

    task automatic check_good(input logic [27:0] data, input int n, input string lane);
        logic [27:0] dm;
        dm = (n == 28) ? data : (data & ((28'd1 << n) - 28'd1));
        chk("R3", "command flag", cmd_sync, ecmd);
        chk("R3", "data flag", data_sync, edat);
        chk("R7", "take_data rise cycle", take_rise, p0 + 18);
        chk("R7", "take_data width", take_cnt, 12 * n);
        chk("R5", "bits shifted out", ncap, n);
        chk(lane, "received word", cap, dm);
        chk("R6", "first shift strobe cycle", stb_first, p0 + 22);
        chk("R10", "word_ok rise cycle", ok_rise, p0 + 18 + 12 * (n + 1));
        chk("R10", "word_ok width", ok_cnt, 12);
    endtask

    initial begin
        set_line(1'b1);
        repeat (3) @(negedge clk);
        chk("R12", "outputs in reset", {cmd_sync, data_sync, take_data, ser_data, shift_stb, word_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            bip_mode = v.bip;
            send_frame(v.cmd, v.code, v.data, v.odd, v.badp, int'(v.fault), int'(v.fbit), 18, -1);
            ecmd = v.cmd;
            edat = !v.cmd;
            if (v.fault == 2'd0 && !v.badp) begin
                check_good(v.data, exp_len(v.code), v.bip ? "R1" : "R6");
            end else if (v.badp) begin
                chk("R9", "word_ok on parity error", ok_cnt, 0);
            end else if (v.fault == 2'd3) begin
                chk("R2", "word_ok with idle pair held", ok_cnt, 0);
            end else begin
                chk("R8", "word_ok on bad bit timing", ok_cnt, 0);
                chk("R3", "flags after dropped word", {cmd_sync, data_sync}, {ecmd, edat});
            end
        end

        // sync first half at the upper tolerance edge is accepted
        bip_mode = 1'b0;
        send_frame(1'b1, 5'd4, 28'h0000015, 1'b0, 1'b0, 0, 0, 21, -1);
        ecmd = 1'b1; edat = 1'b0;
        check_good(28'h0000015, 6, "R3");

        // sync span too long: no word, flags unchanged (first data bit low keeps later runs long)
        send_frame(1'b0, 5'd4, 28'h0000015, 1'b0, 1'b0, 0, 0, 21, -1);
        ecmd = 1'b0; edat = 1'b1;
        send_frame(1'b1, 5'd4, 28'h0000015, 1'b0, 1'b0, 0, 0, 23, -1);
        chk("R4", "take_data on long sync span", take_cnt, 0);
        chk("R4", "word_ok on long sync span", ok_cnt, 0);
        chk("R4", "flags kept after long span", {cmd_sync, data_sync}, {ecmd, edat});

        // decoder reset inside a word
        send_frame(1'b1, 5'd8, 28'h00003A5, 1'b1, 1'b0, 0, 0, 18, 3);
        chk("R11", "word_ok after reset word", ok_cnt, 0);
        chk("R11", "flags stay clear", {cmd_sync, data_sync}, 0);

        // master reset after a good word clears everything at once
        send_frame(1'b0, 5'd2, 28'h000000B, 1'b1, 1'b0, 0, 0, 18, -1);
        chk("R3", "data flag before master reset", data_sync, 1);
        #2 rst_n = 1'b0;
        #1 chk("R12", "outputs after master reset", {cmd_sync, data_sync, take_data, word_ok}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 200000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule